// File: doc/BRIEF.md
# Floating-Point Status and Exception Register

This block holds the floating-point status and control word for a processor core and turns the exception indications from an external floating-point datapath into sticky status and trap requests. Each time the datapath completes an operation, it presents five raw exception indications. The block replaces the per-operation flag field with them and accumulates them into a cause field. When an accumulated cause meets its enable bit, it raises a trap request that carries a fixed exception code.

Software may overwrite the word in a single cycle. Only the defined bits are kept, and all other bits read as zero. The rounding-mode and denormal-flush controls are decoded from the stored word and driven straight to the datapath. Floating-point compares also report here. An ordered compare sets or clears a single truth bit. An unordered compare leaves that bit alone and is treated as an exception-reporting operation.

The word layout is as follows:

| Bits | Field |
|---|---|
| [1:0] | rounding mode |
| [6:2] | flags |
| [11:7] | enables |
| [17:12] | cause |
| 18 | denormal flush |
| 19, 20, 21 | precision, transfer size and bank select (stored only) |

Within the flag, enable and cause fields, element k (k = 0..4) is inexact, underflow, overflow, divide-by-zero and invalid respectively. Cause bit 17 has no exception or enable of its own.

Top module: `fpsr_exc_unit`

## Requirements
- R1: While reset is low, and after its release until the first event, `csr_value` is 0, `trap_req` is 0, `trap_code` is 0 and `t_flag` is 0.
- R2: On an exception update (`op_done`, or `cmp_done` with `cmp_unord`), the flag field [6:2] is replaced by `op_exc`. Bit `op_exc[k]` lands in bit 2+k, where k=0 is inexact, 1 underflow, 2 overflow, 3 divide-by-zero and 4 invalid. Flags from earlier operations are not kept.
- R3: On an exception update, cause bit 12+k becomes the OR of its old value and `op_exc[k]`. Cause bits are never cleared by an update.
- R4: An exception update with `op_exc` equal to zero clears the flag field, leaves every other bit of `csr_value` unchanged, and raises no trap.
- R5: In the cycle after an exception update, `trap_req` is 1 and `trap_code` is 0x120 exactly when two conditions hold: `op_exc` is nonzero, and the updated cause bits [16:12] ANDed with the enable bits [11:7] (element k at 7+k) are nonzero. The cause bits may include causes left from earlier operations. In all other cycles `trap_req` is 0 and `trap_code` is 0.
- R6: A software load (`sw_load`) sets `csr_value` to `sw_data & 32'h003F_FFFF` on the next edge. Bits [31:22] always read zero.
- R7: `round_to_zero` is 1 exactly when bits [1:0] of `csr_value` equal 2'b01. Every other value selects round-to-nearest-even, with `round_to_zero` at 0.
- R8: `flush_denorm` equals bit 18 of `csr_value`.
- R9: An ordered compare (`cmp_done` with `cmp_unord` low) loads `cmp_hit` into `t_flag` on the next edge and leaves `csr_value` unchanged.
- R10: An unordered compare leaves `t_flag` unchanged and updates the flags, cause and trap as in R2 to R5.
- R11: If a software load and an exception update fall in the same cycle, the load alone decides `csr_value`, and no trap is raised for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_load | input | 1 | Software write strobe |
| sw_data | input | 32 | Software write value |
| op_done | input | 1 | Datapath operation completed |
| op_exc | input | 5 | Raw exception indications {invalid, div-zero, overflow, underflow, inexact} |
| cmp_done | input | 1 | Compare completed |
| cmp_unord | input | 1 | Compare was unordered |
| cmp_hit | input | 1 | Ordered compare result (condition true) |
| csr_value | output | 32 | Current status and control word |
| round_to_zero | output | 1 | Truncating rounding selected |
| flush_denorm | output | 1 | Flush denormals to zero |
| trap_req | output | 1 | One-cycle floating-point trap request |
| trap_code | output | 12 | Exception code, 0x120 while `trap_req` is high |
| t_flag | output | 1 | Compare truth bit |

## Verification
A software load and an exception update can fall in the same cycle. They collide in the bench when `sw_load` and `op_done` are strobed together while the incoming exception has its enable bit set in the current word. The bench judges the collision by two results on the next cycle: the word must equal the masked load value with no trace of the exception, and `trap_req` must stay low. Ordered and unordered compares are also interleaved with exception updates, which confirms that the truth bit and the flag path never disturb each other.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
    localparam int unsigned CSR_W     = 32;
    localparam int unsigned EXC_N     = 5;
    localparam int unsigned RM_LSB    = 0;
    localparam int unsigned RM_W      = 2;
    localparam int unsigned FLAG_LSB  = 2;
    localparam int unsigned EN_LSB    = FLAG_LSB + EXC_N;
    localparam int unsigned CAUSE_LSB = EN_LSB + EXC_N;
    localparam int unsigned CAUSE_W   = EXC_N + 1;
    localparam int unsigned DN_POS    = CAUSE_LSB + CAUSE_W;
    localparam int unsigned USED_W    = DN_POS + 4;

    localparam logic [CSR_W-1:0] WR_MASK  = CSR_W'((64'd1 << USED_W) - 64'd1);
    localparam logic [RM_W-1:0]  RM_TRUNC = RM_W'(1);

    typedef struct packed {
        logic             live;
        logic             tbit;
        logic             trap;
        logic [CSR_W-1:0] csr;
    } fpsr_state_t;
endpackage

// File: rtl/fpsr_flag_merge.sv
module fpsr_flag_merge
    import fpsr_pkg::*;
(
    input  logic [CSR_W-1:0] csr_in,
    input  logic [EXC_N-1:0] exc,
    output logic [CSR_W-1:0] csr_out,
    output logic             trap_hit
);
    logic [CAUSE_W-1:0] cause_old;
    logic [CAUSE_W-1:0] cause_new;
    logic [EXC_N-1:0]   enable;
    logic [EXC_N-1:0]   fire;

    assign cause_old = csr_in[CAUSE_LSB +: CAUSE_W];
    assign enable    = csr_in[EN_LSB +: EXC_N];

    // per-exception accumulation and enable match
    for (genvar k = 0; k < EXC_N; k++) begin : g_bit
        assign cause_new[k] = cause_old[k] | exc[k];
        assign fire[k]      = cause_new[k] & enable[k];
    end

    if (CAUSE_W > EXC_N) begin : g_spare
        assign cause_new[CAUSE_W-1:EXC_N] = cause_old[CAUSE_W-1:EXC_N];
    end

    always_comb begin
        csr_out                         = csr_in;
        csr_out[FLAG_LSB +: EXC_N]      = exc;
        csr_out[CAUSE_LSB +: CAUSE_W]   = cause_new;
    end

    // a trap needs a fresh indication and an enabled accumulated cause
    assign trap_hit = (|exc) & (|fire);
endmodule

// File: rtl/fpsr_mode_decode.sv
module fpsr_mode_decode
    import fpsr_pkg::*;
(
    input  logic [RM_W-1:0] rm_field,
    input  logic            dn_bit,
    output logic            round_to_zero,
    output logic            flush_denorm
);
    assign round_to_zero = (rm_field == RM_TRUNC);
    assign flush_denorm  = dn_bit;
endmodule

// File: rtl/fpsr_exc_unit.sv
module fpsr_exc_unit
    import fpsr_pkg::*;
#(
    parameter int unsigned          CODE_W    = 12,
    parameter logic [CODE_W-1:0]    TRAP_CODE = CODE_W'('h120)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_load,
    input  logic [CSR_W-1:0]  sw_data,
    input  logic              op_done,
    input  logic [EXC_N-1:0]  op_exc,
    input  logic              cmp_done,
    input  logic              cmp_unord,
    input  logic              cmp_hit,
    output logic [CSR_W-1:0]  csr_value,
    output logic              round_to_zero,
    output logic              flush_denorm,
    output logic              trap_req,
    output logic [CODE_W-1:0] trap_code,
    output logic              t_flag
);
    fpsr_state_t st_d, st_q;

    logic             upd_req;
    logic [CSR_W-1:0] merged_csr;
    logic             merged_trap;

    assign upd_req = op_done | (cmp_done & cmp_unord);

    fpsr_flag_merge u_merge (
        .csr_in   (st_q.csr),
        .exc      (op_exc),
        .csr_out  (merged_csr),
        .trap_hit (merged_trap)
    );

    fpsr_mode_decode u_mode (
        .rm_field      (st_q.csr[RM_LSB +: RM_W]),
        .dn_bit        (st_q.csr[DN_POS]),
        .round_to_zero (round_to_zero),
        .flush_denorm  (flush_denorm)
    );

    always_comb begin
        st_d      = st_q;
        st_d.live = 1'b1;
        st_d.trap = 1'b0;
        if (sw_load) begin
            st_d.csr = sw_data & WR_MASK;
        end else if (upd_req) begin
            st_d.csr  = merged_csr;
            st_d.trap = merged_trap;
        end
        if (cmp_done && !cmp_unord) begin
            st_d.tbit = cmp_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign csr_value = st_q.csr;
    assign trap_req  = st_q.trap;
    assign trap_code = st_q.trap ? TRAP_CODE : '0;
    assign t_flag    = st_q.tbit;

    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        csr_value[CSR_W-1:USED_W] == '0);

    assert_load_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.live && $past(sw_load)) |-> (csr_value == ($past(sw_data) & WR_MASK)));

    assert_trap_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> ((csr_value[CAUSE_LSB +: EXC_N] & csr_value[EN_LSB +: EXC_N]) != '0));

    assert_trap_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (trap_code == TRAP_CODE));

    assert_no_trap_on_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.live && $past(sw_load)) |-> !trap_req);

    assert_t_hold_unord_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.live && $past(cmp_done && cmp_unord)) |-> (t_flag == $past(t_flag)));

    assert_cause_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.live && !$past(sw_load)) |->
        ((csr_value[CAUSE_LSB +: CAUSE_W] & $past(csr_value[CAUSE_LSB +: CAUSE_W]))
            == $past(csr_value[CAUSE_LSB +: CAUSE_W])));
endmodule

// File: tb/tb_fpsr_exc_unit.sv
module tb_fpsr_exc_unit;
    typedef struct {
        logic [31:0] csr;
        logic        trap;
        logic [11:0] code;
        logic        tbit;
        logic        rz;
        logic        fd;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_load = 1'b0;
    logic [31:0] sw_data = '0;
    logic        op_done = 1'b0;
    logic [4:0]  op_exc = '0;
    logic        cmp_done = 1'b0;
    logic        cmp_unord = 1'b0;
    logic        cmp_hit = 1'b0;
    logic [31:0] csr_value;
    logic        round_to_zero, flush_denorm, trap_req, t_flag;
    logic [11:0] trap_code;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    exp_t  expq[$];
    string tagq[$];

    logic [31:0] m_csr = '0;
    logic        m_t   = 1'b0;

    always #4 clk = ~clk;

    fpsr_exc_unit dut (
        .clk(clk), .rst_n(rst_n), .sw_load(sw_load), .sw_data(sw_data),
        .op_done(op_done), .op_exc(op_exc), .cmp_done(cmp_done),
        .cmp_unord(cmp_unord), .cmp_hit(cmp_hit), .csr_value(csr_value),
        .round_to_zero(round_to_zero), .flush_denorm(flush_denorm),
        .trap_req(trap_req), .trap_code(trap_code), .t_flag(t_flag)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus and push the expected outcome
    task automatic step(input logic ld, input logic [31:0] d, input logic od, input logic [4:0] ex,
                        input logic cd, input logic un, input logic hit, input string tag);
        exp_t e;
        logic [5:0] cause;
        logic       tr;
        @(negedge clk);
        sw_load = ld; sw_data = d; op_done = od; op_exc = ex;
        cmp_done = cd; cmp_unord = un; cmp_hit = hit;
        tr = 1'b0;
        if (ld) begin
            m_csr = d & 32'h003F_FFFF;
        end else if (od || (cd && un)) begin
            cause = m_csr[17:12] | {1'b0, ex};
            tr = (ex != 5'd0) && ((cause[4:0] & m_csr[11:7]) != 5'd0);
            m_csr[6:2]   = ex;
            m_csr[17:12] = cause;
        end
        if (cd && !un) m_t = hit;
        e.csr  = m_csr;
        e.trap = tr;
        e.code = tr ? 12'h120 : 12'h000;
        e.tbit = m_t;
        e.rz   = (m_csr[1:0] == 2'b01);
        e.fd   = m_csr[18];
        expq.push_back(e);
        tagq.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 32'h0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    // monitor: compare after each active edge
    always @(posedge clk) begin
        #2;
        if (expq.size() > 0) begin
            exp_t  e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            check(t, "csr_value", csr_value, e.csr);
            check(t, "trap_req/code", {19'd0, trap_req, trap_code}, {19'd0, e.trap, e.code});
            check(t, "t_flag", {31'd0, t_flag}, {31'd0, e.tbit});
            check(t, "modes", {30'd0, round_to_zero, flush_denorm}, {30'd0, e.rz, e.fd});
        end
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "reset csr", csr_value, 32'h0);
        check("R1", "reset trap", {19'd0, trap_req, trap_code}, 32'h0);
        check("R1", "reset t", {31'd0, t_flag}, 32'h0);
        rst_n = 1'b1;
        idle("R1 post-reset idle");

        step(1, 32'hFFFF_FFFF, 0, 5'd0, 0, 0, 0, "R6 R7 R8 full load masked");
        step(1, 32'h0004_0001, 0, 5'd0, 0, 0, 0, "R7 R8 truncate and flush");
        step(1, 32'h0000_0002, 0, 5'd0, 0, 0, 0, "R7 rm=2 nearest");
        step(1, 32'h0000_0000, 0, 5'd0, 0, 0, 0, "R6 clear");
        step(0, 0, 1, 5'b00001, 0, 0, 0, "R2 R3 inexact");
        step(0, 0, 1, 5'b10000, 0, 0, 0, "R2 R3 invalid replaces flags");
        step(0, 0, 1, 5'b00110, 0, 0, 0, "R2 R3 overflow+underflow");
        step(0, 0, 1, 5'b00000, 0, 0, 0, "R4 no exception");
        step(1, 32'h0000_0400, 0, 5'd0, 0, 0, 0, "R6 enable divzero");
        step(0, 0, 1, 5'b01000, 0, 0, 0, "R5 enabled divzero traps");
        idle("R5 trap drops");
        step(0, 0, 1, 5'b00001, 0, 0, 0, "R5 old cause enabled traps");
        step(0, 0, 1, 5'b00000, 0, 0, 0, "R4 no trap without indication");
        step(1, 32'h0000_0080, 0, 5'd0, 0, 0, 0, "R6 enable inexact");
        step(0, 0, 1, 5'b00010, 0, 0, 0, "R5 non-enabled no trap");
        step(0, 0, 0, 5'd0, 1, 0, 1, "R9 ordered hit");
        step(0, 0, 0, 5'd0, 1, 0, 0, "R9 ordered miss");
        step(0, 0, 0, 5'd0, 1, 0, 1, "R9 ordered hit again");
        step(0, 0, 0, 5'b10000, 1, 1, 0, "R10 unordered keeps t");
        step(0, 0, 0, 5'b00001, 1, 1, 1, "R10 unordered enabled trap");
        step(1, 32'h0000_0F80, 1, 5'b11111, 0, 0, 0, "R11 load with update");
        step(0, 0, 1, 5'b00100, 0, 0, 0, "R5 after collision");
        step(1, 32'hFFC0_0001, 1, 5'b00001, 1, 0, 0, "R11 R9 load update compare");
        idle("R8 idle");

        lf = 16'hACE1;
        for (int i = 0; i < 60; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0] & lf[7], {lf, lf[3:0], lf[15:4]}, lf[1], lf[6:2], lf[8], lf[9], lf[10],
                 "R2 R3 R5 mixed");
        end
        idle("R4 drain");
        repeat (3) @(posedge clk);
        #3;
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule